// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Core with Selectable Deselect Timing

This block is a synthesizable behavioural model of a pipelined synchronous static RAM. It has a 36-bit data path made of four 9-bit byte lanes and a depth set by a parameter. Address, chip select and the write controls are captured on the rising clock edge. A write stores its data at the same edge as the command. A read presents its data one clock after the command. Because the model has no bidirectional pins, it reports whether the data pins would be driven on a separate flag, `drive_o`, and places the read value on `rdata_o`.

A strap input selects when the driver turns off after a deselect. In single-stage mode the driver is cut off as soon as the deselect has been registered, which is one stage ahead of read data. In two-stage mode the driver turns off at the same stage as read data. An asynchronous output-enable input can only mask a driver that the pipeline has marked active. A read issued while the output enable is high is a dummy read: it runs through the pipeline, but the output stays off.

A sleep input stops the block two clocks after it rises. Memory contents are kept while asleep. After sleep ends, a parameterised recovery window follows. A write attempted inside that window is dropped and raises a protocol error flag.

Top module: `sync_sram_pipe`

## Requirements
- R1: After reset, `drive_o` and `proto_err_o` are 0 and `rdata_o` is all zeros.
- R2: A read sampled at edge N places the stored word on `rdata_o` after edge N+1. Every byte lane is returned, whatever the byte enables are.
- R3: With `gw_n_i` low, a selected cycle (`cs_n_i` low) writes all four bytes, whatever `bwe_n_i` and `ben_n_i` are.
- R4: With `gw_n_i` high and `bwe_n_i` low, only the bytes whose `ben_n_i` bit is 0 are written. Bit k covers data bits 9k+8..9k. If all four bits are 1, or if `bwe_n_i` is high, the cycle is a read.
- R5: With `scd_sel_i` = 0 (two-stage deselect), a read at edge N followed by a deselect at edge N+1 still drives its data after edge N+1. The driver is off after edge N+2.
- R6: With `scd_sel_i` = 1 (single-stage deselect), a deselect registered at edge N+1 turns the driver off right after that edge, even if a read was sampled at edge N.
- R7: A write never produces a driven output stage: after the edge that follows a registered write, `drive_o` is 0.
- R8: `oe_n_i` high forces `drive_o` low at once, with no clock edge needed. A read issued with `oe_n_i` high completes with the output off, and a write may follow it in the next cycle.
- R9: Sleep takes effect two edges after `sleep_i` is first sampled high. Commands at those two edges still execute. Later commands are ignored, `drive_o` stays 0, and memory contents are kept.
- R10: For REC_CYC edges after the edge at which `sleep_i` is sampled low again, a write is dropped and `proto_err_o` is 1 after that edge. Reads during this window run normally and do not set the flag.
- R11: A read at the edge after a write to the same address returns the new data. A read followed at the next edge by a write to the same address returns the old data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW | Word address |
| cs_n_i | input | 1 | Chip select, active low; high = deselect |
| gw_n_i | input | 1 | Global write, active low |
| bwe_n_i | input | 1 | Byte-write qualifier, active low |
| ben_n_i | input | NBYTES | Per-byte write enables, active low |
| wdata_i | input | DW | Write data, taken at the command edge |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep request, active high |
| scd_sel_i | input | 1 | 1 = single-stage deselect, 0 = two-stage deselect |
| rdata_o | output | DW | Read data register |
| drive_o | output | 1 | High when the data pins would be driven |
| proto_err_o | output | 1 | Write attempted during sleep recovery |

## Verification
The bench keeps its own model of the memory and of the driver pipeline and runs traffic through both.

- **Read streams and deselects.** Back-to-back reads and read–deselect pairs run once in two-stage mode and again in single-stage mode. They show how far each mode lets read data out before a deselect cuts the driver.
- **Write controls.** Global writes, masked byte writes, and a byte write with no bytes enabled (which must act as a read) separate the write decoding paths from the read path.
- **Same-address hazards.** Write-then-read and read-then-write on one address pin down the ordering of the memory port at a shared edge.
- **Output enable.** Dummy reads and an output-enable pulse in the middle of a cycle confirm that the enable masks the driver without a clock edge.
- **Sleep.** A write burst straddling sleep entry, followed by a write and a read inside the recovery window, marks the exact edges at which commands stop and start to count.

// File: rtl/sps_pkg.sv
package sps_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;

endpackage

// File: rtl/sps_cmd_decode.sv
module sps_cmd_decode
  import sps_pkg::*;
#(
  parameter int NBYTES = 4
) (
  input  logic              cs_n_i,
  input  logic              gw_n_i,
  input  logic              bwe_n_i,
  input  logic [NBYTES-1:0] ben_n_i,
  output cmd_e              cmd_o,
  output logic [NBYTES-1:0] wmask_o
);

  always_comb begin
    if (!gw_n_i) begin
      wmask_o = '1;
    end else if (!bwe_n_i) begin
      wmask_o = ~ben_n_i;
    end else begin
      wmask_o = '0;
    end

    if (cs_n_i) begin
      cmd_o = CMD_IDLE;
    end else if (|wmask_o) begin
      cmd_o = CMD_WRITE;
    end else begin
      cmd_o = CMD_READ;
    end
  end

endmodule

// File: rtl/sps_mem_array.sv
module sps_mem_array #(
  parameter int DEPTH  = 16,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we_i,
  input  logic [NBYTES-1:0]        wmask_i,
  input  logic [AW-1:0]            waddr_i,
  input  logic [NBYTES*BYTE_W-1:0] wdata_i,
  input  logic                     re_i,
  input  logic [AW-1:0]            raddr_i,
  output logic [NBYTES*BYTE_W-1:0] rdata_o
);

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] lane_q [DEPTH];
    logic [BYTE_W-1:0] rd_q;
    logic [BYTE_W-1:0] rd_d;
    logic              lane_we;

    assign lane_we = we_i & wmask_i[b];
    assign rd_d    = lane_q[raddr_i];

    always_ff @(posedge clk) begin
      if (lane_we) begin
        lane_q[waddr_i] <= wdata_i[b*BYTE_W +: BYTE_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_q <= '0;
      end else if (re_i) begin
        rd_q <= rd_d;
      end
    end

    assign rdata_o[b*BYTE_W +: BYTE_W] = rd_q;
  end

endmodule

// File: rtl/sps_drive_ctl.sv
module sps_drive_ctl
  import sps_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic scd_sel_i,
  input  logic asleep_i,
  input  cmd_e cmd_i,
  output logic s1_rd_o,
  output logic drv_o
);

  logic s1_rd_q, s1_wr_q, s1_ds_q, s2_rd_q;
  logic s1_rd_d, s1_wr_d, s1_ds_d, s2_rd_d;

  always_comb begin
    s1_rd_d = (cmd_i == CMD_READ);
    s1_wr_d = (cmd_i == CMD_WRITE);
    s1_ds_d = (cmd_i == CMD_IDLE);
    s2_rd_d = s1_rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_rd_q <= 1'b0;
      s1_wr_q <= 1'b0;
      s1_ds_q <= 1'b1;
      s2_rd_q <= 1'b0;
    end else begin
      s1_rd_q <= s1_rd_d;
      s1_wr_q <= s1_wr_d;
      s1_ds_q <= s1_ds_d;
      s2_rd_q <= s2_rd_d;
    end
  end

  // single-stage mode cuts the driver as soon as a deselect is registered
  assign drv_o   = s2_rd_q & ~(scd_sel_i & s1_ds_q) & ~asleep_i;
  assign s1_rd_o = s1_rd_q;

  p_stage_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({s1_rd_q, s1_wr_q, s1_ds_q}));

  p_desel_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s1_ds_q |=> !drv_o);

  p_write_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s1_wr_q |=> !drv_o);

endmodule

// File: rtl/sps_sleep_ctl.sv
module sps_sleep_ctl #(
  parameter int REC_CYC = 4,
  parameter int RCW     = $clog2(REC_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_i,
  input  logic wr_req_i,
  output logic asleep_o,
  output logic rec_o,
  output logic err_o
);

  logic           pend_q, pend_d;
  logic           asleep_q, asleep_d;
  logic [RCW-1:0] rec_q, rec_d;
  logic           err_q, err_d;
  logic           rec_act;

  assign rec_act = (rec_q != '0);

  always_comb begin
    pend_d   = sleep_i;
    asleep_d = sleep_i & (asleep_q | pend_q);
    if (asleep_q && !sleep_i) begin
      rec_d = RCW'(REC_CYC);
    end else if (rec_act) begin
      rec_d = rec_q - 1'b1;
    end else begin
      rec_d = rec_q;
    end
    err_d = wr_req_i & rec_act & ~asleep_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      asleep_q <= 1'b0;
      rec_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      pend_q   <= pend_d;
      asleep_q <= asleep_d;
      rec_q    <= rec_d;
      err_q    <= err_d;
    end
  end

  assign asleep_o = asleep_q;
  assign rec_o    = rec_act;
  assign err_o    = err_q;

  p_sleep_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep_q) |-> ($past(sleep_i) && $past(sleep_i, 2)));

  p_err_in_rec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> ($past(rec_q) != '0));

endmodule

// File: rtl/sync_sram_pipe.sv
module sync_sram_pipe
  import sps_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int NBYTES  = 4,
  parameter int BYTE_W  = 9,
  parameter int REC_CYC = 4,
  parameter int AW      = $clog2(DEPTH),
  parameter int DW      = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr_i,
  input  logic              cs_n_i,
  input  logic              gw_n_i,
  input  logic              bwe_n_i,
  input  logic [NBYTES-1:0] ben_n_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              oe_n_i,
  input  logic              sleep_i,
  input  logic              scd_sel_i,
  output logic [DW-1:0]     rdata_o,
  output logic              drive_o,
  output logic              proto_err_o
);

  cmd_e              cmd_raw, cmd_acc;
  logic [NBYTES-1:0] wmask;
  logic              asleep, in_rec, s1_rd, drv;
  logic [AW-1:0]     raddr_q, raddr_d;

  sps_cmd_decode #(.NBYTES(NBYTES)) u_dec (
    .cs_n_i  (cs_n_i),
    .gw_n_i  (gw_n_i),
    .bwe_n_i (bwe_n_i),
    .ben_n_i (ben_n_i),
    .cmd_o   (cmd_raw),
    .wmask_o (wmask)
  );

  sps_sleep_ctl #(.REC_CYC(REC_CYC)) u_sleep (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep_i  (sleep_i),
    .wr_req_i (cmd_raw == CMD_WRITE),
    .asleep_o (asleep),
    .rec_o    (in_rec),
    .err_o    (proto_err_o)
  );

  // sleeping drops every command; recovery drops writes only
  always_comb begin
    if (asleep) begin
      cmd_acc = CMD_IDLE;
    end else if (in_rec && cmd_raw == CMD_WRITE) begin
      cmd_acc = CMD_IDLE;
    end else begin
      cmd_acc = cmd_raw;
    end
    raddr_d = (cmd_acc == CMD_READ) ? addr_i : raddr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raddr_q <= '0;
    end else begin
      raddr_q <= raddr_d;
    end
  end

  sps_drive_ctl u_drv (
    .clk       (clk),
    .rst_n     (rst_n),
    .scd_sel_i (scd_sel_i),
    .asleep_i  (asleep),
    .cmd_i     (cmd_acc),
    .s1_rd_o   (s1_rd),
    .drv_o     (drv)
  );

  sps_mem_array #(
    .DEPTH (DEPTH),
    .NBYTES(NBYTES),
    .BYTE_W(BYTE_W),
    .AW    (AW)
  ) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (cmd_acc == CMD_WRITE),
    .wmask_i (wmask),
    .waddr_i (addr_i),
    .wdata_i (wdata_i),
    .re_i    (s1_rd),
    .raddr_i (raddr_q),
    .rdata_o (rdata_o)
  );

  assign drive_o = drv & ~oe_n_i;

  p_sleep_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |=> !s1_rd);

endmodule

// File: tb/sim_sync_sram_pipe.sv
module sim_sync_sram_pipe;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  addr_i;
  logic        cs_n_i, gw_n_i, bwe_n_i, oe_n_i, sleep_i, scd_sel_i;
  logic [3:0]  ben_n_i;
  logic [35:0] wdata_i;
  logic [35:0] rdata_o;
  logic        drive_o, proto_err_o;

  int checks = 0;
  int errors = 0;
  int ecount = 0;
  bit sb_on  = 1'b1;
  bit done   = 1'b0;

  typedef struct {
    int          edge_n;
    logic        drv;
    logic [35:0] data;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  logic [35:0] model [16];
  bit          prev_rd = 1'b0;
  logic [35:0] prev_data = '0;

  always #(PERIOD/2) clk = ~clk;

  sync_sram_pipe u0 (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .cs_n_i(cs_n_i),
    .gw_n_i(gw_n_i), .bwe_n_i(bwe_n_i), .ben_n_i(ben_n_i),
    .wdata_i(wdata_i), .oe_n_i(oe_n_i), .sleep_i(sleep_i),
    .scd_sel_i(scd_sel_i), .rdata_o(rdata_o), .drive_o(drive_o),
    .proto_err_o(proto_err_o)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares scoreboard items for the edge just passed
  always @(posedge clk) begin
    ecount++;
    #2;
    while (sb_q.size() > 0 && sb_q[0].edge_n <= ecount) begin
      item_t it;
      it = sb_q.pop_front();
      chk(drive_o === it.drv, {it.tag, " drive"}, 36'(drive_o), 36'(it.drv));
      if (it.drv) chk(rdata_o === it.data, {it.tag, " data"}, rdata_o, it.data);
    end
  end

  // driver: one command per clock; pushes the output expected after its edge
  task automatic step(input bit cs_n, input bit gw_n, input bit bwe_n,
                      input bit [3:0] ben, input int a,
                      input logic [35:0] d, input bit oe, input string tag);
    bit desel, wr, rd;
    bit [3:0] mask;
    item_t it;
    @(negedge clk);
    mask  = !gw_n ? 4'hF : (!bwe_n ? ~ben : 4'h0);
    desel = cs_n;
    wr    = !cs_n && (mask != 4'h0);
    rd    = !cs_n && !wr;
    if (sb_on) begin
      it.edge_n = ecount + 1;
      it.drv    = prev_rd && !(scd_sel_i && desel) && !oe;
      it.data   = prev_data;
      it.tag    = tag;
      sb_q.push_back(it);
    end
    if (rd) prev_data = model[a];
    prev_rd = rd;
    if (wr) begin
      for (int b = 0; b < 4; b++)
        if (mask[b]) model[a][b*9 +: 9] = d[b*9 +: 9];
    end
    cs_n_i = cs_n; gw_n_i = gw_n; bwe_n_i = bwe_n; ben_n_i = ben;
    addr_i = 4'(a); wdata_i = d; oe_n_i = oe;
  endtask

  task automatic rd_cmd(input int a, input bit oe, input string tag);
    step(1'b0, 1'b1, 1'b1, 4'hF, a, '0, oe, tag);
  endtask

  task automatic gw_cmd(input int a, input logic [35:0] d, input bit oe, input string tag);
    step(1'b0, 1'b0, 1'b1, 4'hF, a, d, oe, tag);
  endtask

  task automatic ds_cmd(input bit oe, input string tag);
    step(1'b1, 1'b1, 1'b1, 4'hF, 0, '0, oe, tag);
  endtask

  task automatic raw(input bit cs_n, input bit gw_n, input int a,
                     input logic [35:0] d, input bit oe, input bit slp);
    @(negedge clk);
    cs_n_i = cs_n; gw_n_i = gw_n; bwe_n_i = 1'b1; ben_n_i = 4'hF;
    addr_i = 4'(a); wdata_i = d; oe_n_i = oe; sleep_i = slp;
  endtask

  task automatic after_edge();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", ecount, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n_i = 1'b1; gw_n_i = 1'b1; bwe_n_i = 1'b1;
    ben_n_i = 4'hF; addr_i = '0; wdata_i = '0; oe_n_i = 1'b0;
    sleep_i = 1'b0; scd_sel_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(drive_o === 1'b0, "R1 drive", 36'(drive_o), 36'd0);
    chk(proto_err_o === 1'b0, "R1 err", 36'(proto_err_o), 36'd0);
    chk(rdata_o === 36'd0, "R1 rdata", rdata_o, 36'd0);

    // R3 global write ignores byte controls; R4 byte writes
    gw_cmd(0, 36'h1_2345_6789, 1'b0, "R3 gw");
    step(1'b0, 1'b0, 1'b0, 4'hF, 1, 36'hA_BCDE_F012, 1'b0, "R3 gw+bw");
    gw_cmd(2, 36'hF_FFFF_FFFF, 1'b0, "R4 pre");
    step(1'b0, 1'b1, 1'b0, 4'b1010, 2, 36'h0, 1'b0, "R4 mask");
    step(1'b0, 1'b1, 1'b0, 4'hF, 2, 36'h0, 1'b0, "R4 nobyte read");
    step(1'b0, 1'b1, 1'b1, 4'h0, 2, 36'h0, 1'b0, "R4 bwe high read");
    // R2 back-to-back reads, R5 two-stage deselect keeps last read
    rd_cmd(0, 1'b0, "R2 rd0");
    rd_cmd(1, 1'b0, "R2 rd1");
    rd_cmd(2, 1'b0, "R2 rd2");
    ds_cmd(1'b0, "R5 dcd last read");
    ds_cmd(1'b0, "R5 dcd off");
    // R11 same-address ordering
    gw_cmd(4, 36'h5_5555_5555, 1'b0, "R11 wr");
    rd_cmd(4, 1'b0, "R11 rd after wr");
    gw_cmd(4, 36'h6_6666_6666, 1'b0, "R11 old data");
    rd_cmd(4, 1'b0, "R7 wr off");
    ds_cmd(1'b0, "R11 new data");
    // R8 dummy read then write
    rd_cmd(0, 1'b1, "R8 pre");
    gw_cmd(3, 36'h3_3333_3333, 1'b1, "R8 dummy off");
    rd_cmd(3, 1'b0, "R7 write off");
    ds_cmd(1'b0, "R8 read after dummy");
    // R8 asynchronous output enable
    rd_cmd(1, 1'b0, "R8 async pre");
    ds_cmd(1'b0, "R8 async drv");
    @(posedge clk);
    #3;
    chk(drive_o === 1'b1, "R8 before oe", 36'(drive_o), 36'd1);
    oe_n_i = 1'b1;
    #1;
    chk(drive_o === 1'b0, "R8 oe async", 36'(drive_o), 36'd0);
    ds_cmd(1'b0, "R8 idle");
    ds_cmd(1'b0, "R8 idle2");

    // R6 single-stage deselect
    scd_sel_i = 1'b1;
    rd_cmd(0, 1'b0, "R6 pre");
    ds_cmd(1'b0, "R6 cut");
    rd_cmd(0, 1'b0, "R6 rdA");
    rd_cmd(1, 1'b0, "R6 rdB");
    ds_cmd(1'b0, "R6 cut B");
    ds_cmd(1'b0, "R6 idle");
    scd_sel_i = 1'b0;
    gw_cmd(7, 36'h7_0707_0707, 1'b0, "R9 pre");
    ds_cmd(1'b0, "R9 idle");

    // R9 sleep entry, R10 recovery
    sb_on = 1'b0;
    prev_rd = 1'b0;
    raw(1'b0, 1'b0, 5, 36'h5_AAAA_0005, 1'b0, 1'b1);
    raw(1'b0, 1'b0, 6, 36'h6_BBBB_0006, 1'b0, 1'b1);
    raw(1'b0, 1'b0, 7, 36'h0_DEAD_BEEF, 1'b0, 1'b1);
    after_edge();
    chk(drive_o === 1'b0, "R9 asleep drive", 36'(drive_o), 36'd0);
    raw(1'b0, 1'b1, 5, '0, 1'b0, 1'b1);
    raw(1'b1, 1'b1, 0, '0, 1'b0, 1'b1);
    after_edge();
    chk(drive_o === 1'b0, "R9 read ignored", 36'(drive_o), 36'd0);
    raw(1'b1, 1'b1, 0, '0, 1'b0, 1'b0);
    raw(1'b0, 1'b0, 7, 36'h0_BAD0_BAD0, 1'b0, 1'b0);
    after_edge();
    chk(proto_err_o === 1'b1, "R10 err on write", 36'(proto_err_o), 36'd1);
    raw(1'b0, 1'b1, 6, '0, 1'b0, 1'b0);
    after_edge();
    chk(proto_err_o === 1'b0, "R10 read no err", 36'(proto_err_o), 36'd0);
    raw(1'b1, 1'b1, 0, '0, 1'b0, 1'b0);
    after_edge();
    chk(drive_o === 1'b1, "R10 rec read drive", 36'(drive_o), 36'd1);
    chk(rdata_o === 36'h6_BBBB_0006, "R10 rec read data", rdata_o, 36'h6_BBBB_0006);
    repeat (REC_WAIT) raw(1'b1, 1'b1, 0, '0, 1'b0, 1'b0);
    model[5] = 36'h5_AAAA_0005;
    model[6] = 36'h6_BBBB_0006;
    sb_on = 1'b1;
    rd_cmd(5, 1'b0, "R9 idle after");
    rd_cmd(7, 1'b0, "R9 entry write kept");
    rd_cmd(6, 1'b0, "R9 asleep/rec write dropped");
    ds_cmd(1'b0, "R9 second entry write kept");
    ds_cmd(1'b0, "R9 end");
    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "scoreboard drain", 36'(sb_q.size()), 36'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam int REC_WAIT = 4;

endmodule